// File: doc/BRIEF.md
# Host-Coprocessor Mailbox Bridge

This block sits between a byte-wide host bus and an embedded coprocessor. It holds one byte mailbox in each direction, each with its own full flag. It also holds an attention flag that the coprocessor raises, a control bit that holds the coprocessor in reset, and a bridge-ready flag. The host reaches all of these through a small register window. That window is only partly decoded, so it repeats across a wider address range. Reads in the window have side effects: taking the inbound byte empties its mailbox, and reading the attention location clears the attention flag.

A rising edge of the control bit resets the coprocessor side of the bridge. When the control bit is cleared again, the bridge counts a fixed number of clocks before it raises its ready flag. The coprocessor side runs only while that flag is set. On the coprocessor side, a strobe port moves bytes through the mailboxes, raises the attention flag and loads a one-shot down-counter.

Top module: `mbox_bridge`

## Requirements
- R1: A host address is ANDed with 0xFF06 before decode. Offset 0x3800 is the inbound data location, 0x3802 is the attention/outbound data location and 0x3804 is the control/status location. Any other masked value reads 0x00 and has no effect. Address bit 0, bits 3 to 7 and bits 16 and up are therefore ignored.
- R2: A host read at 0x3800 returns the coprocessor-to-host byte and empties that mailbox when it is full. When that mailbox is empty, the read returns 0x00 and changes nothing.
- R3: A host read at 0x3802 returns 0x00 and clears the attention flag.
- R4: A host read at 0x3804 returns the status byte: bit 0 is coprocessor-to-host full, bit 2 is attention, bit 3 is host-to-coprocessor full and bit 7 is bridge ready. All other bits read 0.
- R5: A host write at 0x3802 stores the byte in the host-to-coprocessor mailbox and sets its full flag. `cp_rdata` shows the stored byte. A `cp_rd` strobe empties that mailbox.
- R6: A `cp_wr` strobe stores `cp_wdata` in the coprocessor-to-host mailbox and sets its full flag. A `cp_sig` strobe sets the attention flag.
- R7: A host write at 0x3804 copies data bit 0 into the control bit and ignores data bits 7 to 1. A 0-to-1 change of the control bit resets the coprocessor side: it clears bridge ready, attention, the timer count, the timer reload value and both full flags. Writing 1 while the bit is already 1 does not reset again.
- R8: While the control bit is 1, `cp_run` is low. Bridge ready rises exactly HOLD_CYCLES clock edges after the edge that clears the control bit. The same count applies after `rst_n` is released.
- R9: While `cp_run` is low, the `cp_wr`, `cp_rd`, `cp_sig` and `cp_tmr_ld` strobes are ignored.
- R10: `cp_tmr_ld` loads the timer count and the reload value with `cp_tmr_val`. The count then falls by one on each clock while it is non-zero and stays at zero.
- R11: When a set and a clear reach the same flag in one cycle, the set wins. This covers a host data read against `cp_wr`, a host mailbox write against `cp_rd`, and a host attention read against `cp_sig`.
- R12: A coprocessor-side reset takes priority over set strobes in the same cycle.
- R13: While `rst_n` is low, all flags, the timer and the control bit are zero, and `h_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | ADDR_W | Host address |
| h_rd | input | 1 | Host read strobe, one cycle |
| h_wr | input | 1 | Host write strobe, one cycle |
| h_wdata | input | DATA_W | Host write data |
| h_rdata | output | DATA_W | Host read data, combinational, 0 when not reading |
| cp_rd | input | 1 | Coprocessor takes the inbound byte |
| cp_wr | input | 1 | Coprocessor posts an outbound byte |
| cp_wdata | input | DATA_W | Outbound byte |
| cp_sig | input | 1 | Coprocessor raises attention |
| cp_tmr_ld | input | 1 | Timer load strobe |
| cp_tmr_val | input | TMR_W | Timer load value |
| cp_rdata | output | DATA_W | Host-to-coprocessor mailbox byte |
| cp_rx_full | output | 1 | Host-to-coprocessor mailbox full |
| cp_tx_full | output | 1 | Coprocessor-to-host mailbox full |
| cp_run | output | 1 | Coprocessor may run |
| tmr_count | output | TMR_W | Timer count |
| tmr_reload | output | TMR_W | Last loaded timer value |

## Verification
The bench builds the bridge with HOLD_CYCLES = 12 and TMR_W = 8, keeping ADDR_W = 24 and DATA_W = 8. The short hold-off lets the bench count the ready delay edge by edge, both after `rst_n` and after each control release, and the small timer lets a countdown be followed all the way to its floor. The full 24-bit address lets the bench place accesses in upper banks and at aliased offsets, so the partial decode is exercised.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   localparam logic [15:0] DEC_MASK = 16'hFF06;
   localparam logic [15:0] LOC_DATA = 16'h3800;
   localparam logic [15:0] LOC_SIG  = 16'h3802;
   localparam logic [15:0] LOC_CTL  = 16'h3804;

   localparam int ST_TX  = 0;
   localparam int ST_SIG = 2;
   localparam int ST_RX  = 3;
   localparam int ST_RDY = 7;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DATA = 2'd1,
      SEL_SIG  = 2'd2,
      SEL_CTL  = 2'd3
   } sel_e;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
   import mbox_pkg::*;
#(
   parameter int ADDR_W = 24
) (
   input  logic [ADDR_W-1:0] addr,
   output sel_e              sel
);
   localparam logic [ADDR_W-1:0] MASK_W = ADDR_W'(DEC_MASK);

   if (ADDR_W < 16) begin : g_bad_addr
      $error("mbox_decode: ADDR_W must be at least 16");
   end

   logic [ADDR_W-1:0] masked;
   assign masked = addr & MASK_W;

   always_comb begin
      sel = SEL_NONE;
      if (masked == ADDR_W'(LOC_DATA))     sel = SEL_DATA;
      else if (masked == ADDR_W'(LOC_SIG)) sel = SEL_SIG;
      else if (masked == ADDR_W'(LOC_CTL)) sel = SEL_CTL;
   end
endmodule

// File: rtl/mbox_slot.sv
module mbox_slot #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         kill,
   input  logic         set,
   input  logic         clr,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         full
);
   if (W < 1) begin : g_bad_w
      $error("mbox_slot: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         dout <= '0;
      end else if (kill) begin
         full <= 1'b0;
      end else if (set) begin
         full <= 1'b1;
         dout <= din;
      end else if (clr) begin
         full <= 1'b0;
      end
   end

   // R11
   set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set && !kill) |=> full);
   // R2
   clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set && !kill) |=> !full);
   // R12
   kill_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> !full);
   // R5
   payload_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set && !kill) |=> dout == $past(din));
endmodule

// File: rtl/mbox_holdoff.sv
module mbox_holdoff #(
   parameter int HOLD_CYCLES = 65536
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_wr,
   input  logic ctl_bit,
   output logic kill,
   output logic ctl_q,
   output logic rdy
);
   localparam int CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

   if (HOLD_CYCLES < 2) begin : g_bad_hold
      $error("mbox_holdoff: HOLD_CYCLES must be at least 2");
   end

   logic [CNT_W-1:0] cnt;

   assign kill = ctl_wr & ctl_bit & ~ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= 1'b0;
         rdy   <= 1'b0;
         cnt   <= '0;
      end else begin
         if (ctl_wr) ctl_q <= ctl_bit;
         if (kill) begin
            rdy <= 1'b0;
            cnt <= '0;
         end else if (!ctl_q && !rdy) begin
            if (cnt == LAST) rdy <= 1'b1;
            else             cnt <= cnt + 1'b1;
         end
      end
   end

   // R8
   held_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q |-> !rdy);
   // R8
   ready_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy) |-> !ctl_q);
   // R7
   rise_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_q) |-> !rdy);
endmodule

// File: rtl/mbox_timer.sv
module mbox_timer #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             kill,
   input  logic             ld,
   input  logic [TMR_W-1:0] val,
   output logic [TMR_W-1:0] count,
   output logic [TMR_W-1:0] reload
);
   if (TMR_W < 1) begin : g_bad_tmr
      $error("mbox_timer: TMR_W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count  <= '0;
         reload <= '0;
      end else if (kill) begin
         count  <= '0;
         reload <= '0;
      end else if (ld) begin
         count  <= val;
         reload <= val;
      end else if (count != '0) begin
         count  <= count - 1'b1;
      end
   end

   // R10
   tmr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count != '0 && !ld && !kill) |=> count == $past(count) - 1'b1);
   // R10
   tmr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && !ld && !kill) |=> count == '0);
   // R10
   tmr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && !kill) |=> (count == $past(val)) && (reload == $past(val)));
   // R7
   tmr_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> (count == '0) && (reload == '0));
endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
   import mbox_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int DATA_W      = 8,
   parameter int TMR_W       = 16,
   parameter int HOLD_CYCLES = 65536
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic              h_rd,
   input  logic              h_wr,
   input  logic [DATA_W-1:0] h_wdata,
   output logic [DATA_W-1:0] h_rdata,
   input  logic              cp_rd,
   input  logic              cp_wr,
   input  logic [DATA_W-1:0] cp_wdata,
   input  logic              cp_sig,
   input  logic              cp_tmr_ld,
   input  logic [TMR_W-1:0]  cp_tmr_val,
   output logic [DATA_W-1:0] cp_rdata,
   output logic              cp_rx_full,
   output logic              cp_tx_full,
   output logic              cp_run,
   output logic [TMR_W-1:0]  tmr_count,
   output logic [TMR_W-1:0]  tmr_reload
);
   if (DATA_W < 8) begin : g_bad_data
      $error("mbox_bridge: DATA_W must be at least 8");
   end

   sel_e              sel;
   logic              kill, ctl_q, rdy, sig_q;
   logic              hrd_data, hrd_sig, hwr_box, hwr_ctl;
   logic              cp_wr_ok, cp_rd_ok, cp_sig_ok, cp_ld_ok;
   logic [DATA_W-1:0] tx_data, status;

   mbox_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(h_addr), .sel(sel));

   assign hrd_data = h_rd & (sel == SEL_DATA);
   assign hrd_sig  = h_rd & (sel == SEL_SIG);
   assign hwr_box  = h_wr & (sel == SEL_SIG);
   assign hwr_ctl  = h_wr & (sel == SEL_CTL);

   mbox_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
      .clk(clk), .rst_n(rst_n), .ctl_wr(hwr_ctl), .ctl_bit(h_wdata[0]),
      .kill(kill), .ctl_q(ctl_q), .rdy(rdy));

   assign cp_run    = rdy & ~ctl_q;
   assign cp_wr_ok  = cp_wr & cp_run;
   assign cp_rd_ok  = cp_rd & cp_run;
   assign cp_sig_ok = cp_sig & cp_run;
   assign cp_ld_ok  = cp_tmr_ld & cp_run;

   mbox_slot #(.W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .kill(kill), .set(cp_wr_ok), .clr(hrd_data),
      .din(cp_wdata), .dout(tx_data), .full(cp_tx_full));

   mbox_slot #(.W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .kill(kill), .set(hwr_box), .clr(cp_rd_ok),
      .din(h_wdata), .dout(cp_rdata), .full(cp_rx_full));

   mbox_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .kill(kill), .ld(cp_ld_ok), .val(cp_tmr_val),
      .count(tmr_count), .reload(tmr_reload));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sig_q <= 1'b0;
      else if (kill)      sig_q <= 1'b0;
      else if (cp_sig_ok) sig_q <= 1'b1;
      else if (hrd_sig)   sig_q <= 1'b0;
   end

   always_comb begin
      status         = '0;
      status[ST_TX]  = cp_tx_full;
      status[ST_SIG] = sig_q;
      status[ST_RX]  = cp_rx_full;
      status[ST_RDY] = rdy;
   end

   always_comb begin
      h_rdata = '0;
      if (h_rd) begin
         case (sel)
            SEL_DATA: if (cp_tx_full) h_rdata = tx_data;
            SEL_CTL:  h_rdata = status;
            default:  h_rdata = '0;
         endcase
      end
   end

   // R9
   stalled_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cp_run && !cp_tx_full) |=> !cp_tx_full);
   // R9
   stalled_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cp_run && !sig_q) |=> !sig_q);
   // R3
   sig_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hrd_sig && !cp_sig_ok) |=> !sig_q);
   // R11
   sig_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_sig_ok && !kill) |=> sig_q);
endmodule

// File: tb/sim_mbox_bridge.sv
module sim_mbox_bridge;
   localparam int HOLD = 12;
   localparam int TW   = 8;

   typedef struct packed {
      logic [1:0]  op;   // 0 host write, 1 host read, 2 cop write, 3 cop attention
      logic [3:0]  req;
      logic [23:0] addr;
      logic [7:0]  data;
      logic [7:0]  exp;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t TBL [NV] = '{
      '{2'd2, 4'd6, 24'h000000, 8'h5A, 8'h00}, // R6 post outbound
      '{2'd1, 4'd4, 24'h003804, 8'h00, 8'h81}, // R4 status
      '{2'd1, 4'd2, 24'h003801, 8'h00, 8'h5A}, // R2 R1 take byte via alias
      '{2'd1, 4'd2, 24'h803800, 8'h00, 8'h00}, // R2 empty now
      '{2'd0, 4'd5, 24'h003803, 8'hC3, 8'h00}, // R5 inbound via alias
      '{2'd1, 4'd1, 24'h0038FC, 8'h00, 8'h88}, // R1 status alias
      '{2'd3, 4'd6, 24'h000000, 8'h00, 8'h00}, // R6 attention
      '{2'd1, 4'd4, 24'h003805, 8'h00, 8'h8C}, // R4
      '{2'd1, 4'd3, 24'h003802, 8'h00, 8'h00}, // R3 clear attention
      '{2'd1, 4'd1, 24'h3F3804, 8'h00, 8'h88}, // R1 upper bank
      '{2'd1, 4'd1, 24'h003A00, 8'h00, 8'h00}, // R1 undecoded
      '{2'd1, 4'd1, 24'h003806, 8'h00, 8'h00}, // R1 undecoded
      '{2'd1, 4'd4, 24'h003804, 8'h00, 8'h88}  // R4 unchanged
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [23:0]    h_addr = '0;
   logic           h_rd = 1'b0, h_wr = 1'b0;
   logic [7:0]     h_wdata = '0, h_rdata;
   logic           cp_rd = 1'b0, cp_wr = 1'b0, cp_sig = 1'b0, cp_tmr_ld = 1'b0;
   logic [7:0]     cp_wdata = '0, cp_rdata;
   logic [TW-1:0]  cp_tmr_val = '0, tmr_count, tmr_reload;
   logic           cp_rx_full, cp_tx_full, cp_run;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   mbox_bridge #(.ADDR_W(24), .DATA_W(8), .TMR_W(TW), .HOLD_CYCLES(HOLD)) u0 (
      .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_rd(h_rd), .h_wr(h_wr),
      .h_wdata(h_wdata), .h_rdata(h_rdata), .cp_rd(cp_rd), .cp_wr(cp_wr),
      .cp_wdata(cp_wdata), .cp_sig(cp_sig), .cp_tmr_ld(cp_tmr_ld),
      .cp_tmr_val(cp_tmr_val), .cp_rdata(cp_rdata), .cp_rx_full(cp_rx_full),
      .cp_tx_full(cp_tx_full), .cp_run(cp_run), .tmr_count(tmr_count),
      .tmr_reload(tmr_reload));

   task automatic check(input int req, input logic [31:0] act,
                        input logic [31:0] exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic host_wr(input logic [23:0] a, input logic [7:0] d);
      @(negedge clk);
      h_addr = a; h_wdata = d; h_wr = 1'b1;
      @(negedge clk);
      h_wr = 1'b0;
   endtask

   task automatic host_rd(input logic [23:0] a, output logic [7:0] d);
      @(negedge clk);
      h_addr = a; h_rd = 1'b1;
      #1 d = h_rdata;
      @(negedge clk);
      h_rd = 1'b0;
   endtask

   task automatic cop(input logic w, input logic s, input logic r,
                      input logic l, input logic [7:0] d, input logic [TW-1:0] v);
      @(negedge clk);
      cp_wr = w; cp_sig = s; cp_rd = r; cp_tmr_ld = l; cp_wdata = d; cp_tmr_val = v;
      @(negedge clk);
      cp_wr = 0; cp_sig = 0; cp_rd = 0; cp_tmr_ld = 0;
   endtask

   // R8: called just after the releasing edge
   task automatic wait_hold(input string what);
      repeat (HOLD - 1) @(posedge clk);
      #1 check(8, cp_run, 0, {what, " one edge early"});
      @(posedge clk);
      #1 check(8, cp_run, 1, {what, " on time"});
   endtask

   initial begin
      #(4 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hang expected finish");
      finish_run();
   end

   initial begin
      logic [7:0] rd;
      repeat (3) @(posedge clk);
      #1;
      // R13 reset state
      check(13, h_rdata, 0, "rdata in reset");
      check(13, cp_run, 0, "run in reset");
      check(13, {cp_rx_full, cp_tx_full}, 0, "flags in reset");
      check(13, tmr_count, 0, "timer in reset");
      @(negedge clk);
      rst_n = 1'b1;
      wait_hold("ready after rst_n"); // R8

      for (int i = 0; i < NV; i++) begin
         case (TBL[i].op)
            2'd0: host_wr(TBL[i].addr, TBL[i].data);
            2'd1: begin
               host_rd(TBL[i].addr, rd);
               check(int'(TBL[i].req), rd, TBL[i].exp, $sformatf("table row %0d", i));
            end
            2'd2: cop(1, 0, 0, 0, TBL[i].data, '0);
            default: cop(0, 1, 0, 0, '0, '0);
         endcase
      end

      // R5 coprocessor sees and takes the byte
      check(5, cp_rdata, 8'hC3, "cp_rdata");
      check(5, cp_rx_full, 1, "rx full");
      cop(0, 0, 1, 0, '0, '0);
      check(5, cp_rx_full, 0, "rx emptied");

      // R11 host data read against cp_wr
      cop(1, 0, 0, 0, 8'h11, '0);
      @(negedge clk);
      h_addr = 24'h003800; h_rd = 1; cp_wr = 1; cp_wdata = 8'h22;
      #1 rd = h_rdata;
      @(negedge clk);
      h_rd = 0; cp_wr = 0;
      check(11, rd, 8'h11, "old byte returned");
      check(11, cp_tx_full, 1, "tx set wins");
      host_rd(24'h003800, rd);
      check(11, rd, 8'h22, "new byte kept");
      // R11 host mailbox write against cp_rd
      @(negedge clk);
      h_addr = 24'h003802; h_wdata = 8'h33; h_wr = 1; cp_rd = 1;
      @(negedge clk);
      h_wr = 0; cp_rd = 0;
      check(11, cp_rx_full, 1, "rx set wins");
      check(11, cp_rdata, 8'h33, "rx byte");
      // R11 attention read against cp_sig
      @(negedge clk);
      h_addr = 24'h003802; h_rd = 1; cp_sig = 1;
      @(negedge clk);
      h_rd = 0; cp_sig = 0;
      host_rd(24'h003804, rd);
      check(11, rd, 8'h8C, "attention set wins");

      // R10 timer
      cop(0, 0, 0, 1, '0, 8'd5);
      check(10, tmr_count, 5, "timer loaded");
      check(10, tmr_reload, 5, "reload loaded");
      @(posedge clk); #1 check(10, tmr_count, 4, "timer first step");
      repeat (5) @(posedge clk);
      #1 check(10, tmr_count, 0, "timer floor");
      check(10, tmr_reload, 5, "reload held");

      // R7 upper data bits ignored, no reset on 0
      cop(1, 0, 0, 1, 8'h44, 8'd9);
      host_wr(24'h003804, 8'hFE);
      host_rd(24'h003804, rd);
      check(7, rd, 8'h8D, "bits 7..1 ignored");
      check(7, cp_run, 1, "still running");
      // R7 rising control resets
      host_wr(24'h003804, 8'h01);
      host_rd(24'h003804, rd);
      check(7, rd, 8'h00, "status cleared");
      check(7, {tmr_count, tmr_reload}, 0, "timer cleared");
      check(8, cp_run, 0, "held");
      // R9 strobes ignored while held
      cop(1, 1, 0, 1, 8'h55, 8'd7);
      host_rd(24'h003804, rd);
      check(9, rd, 8'h00, "strobes ignored");
      check(9, tmr_reload, 0, "timer load ignored");
      host_wr(24'h003805, 8'h01);
      host_rd(24'h003804, rd);
      check(7, rd, 8'h00, "repeat 1 no change");
      host_wr(24'h003804, 8'h00);
      wait_hold("ready after release"); // R8
      host_rd(24'h003804, rd);
      check(8, rd, 8'h80, "ready status");

      // R12 reset beats same-cycle sets
      @(negedge clk);
      h_addr = 24'h003804; h_wdata = 8'h01; h_wr = 1;
      cp_wr = 1; cp_wdata = 8'hAA; cp_sig = 1;
      @(negedge clk);
      h_wr = 0; cp_wr = 0; cp_sig = 0;
      host_rd(24'h003804, rd);
      check(12, rd, 8'h00, "reset wins");

      finish_run();
   end
endmodule